// File: doc/BRIEF.md
# Handshaked Serial Command/Response Engine

This block sits on the device side of a byte channel and runs a host's command protocol. The host places each byte in an 8-bit shift path and then pulls a request line low in a small port register. The engine answers by pulling an acknowledge line low and processing the byte. The host then raises the request line, and the engine answers by raising acknowledge again. Both lines are active low. A transaction is made of a command code, an optional length byte, the argument bytes, and then the bytes that the host reads back. The read-back part may begin with a size byte.

A lookup table keyed by the command code gives two values for each command: how many argument bytes it takes and how many response bytes it returns. Either value may be fixed or variable. Once all the arguments are in, the engine raises a one-cycle dispatch strobe toward an external handler. The handler reads the stored arguments by index and, in that same cycle, states whether it knows the command and how large its reply is. The engine then fetches the reply bytes from the handler by index. Every byte that moves in either direction raises a one-cycle done strobe toward the host. Bytes that break the protocol raise an error strobe instead.

Top module: `hs_cmd_engine`

## Requirements
- R1: After reset the port reads 0x18, with request (bit 4) and acknowledge (bit 3) both high. The engine is idle, sr_out is 0, and byte_done, xfer_err and dsp_req are low.
- R2: A port write whose value equals the last value the engine recorded is stored and causes no action: no strobe and no change to the acknowledge bit.
- R3: A changed port write with bit 4 = 1 and bit 3 = 0 is an acknowledge release. The engine sets bit 3 high and does nothing else.
- R4: A changed port write with bit 4 = 0 and bit 3 = 1 is a byte request. The port reads bit 3 low from the next cycle. Exactly one byte is processed, and byte_done pulses for one cycle in the second cycle after the write.
- R5: A changed write with bits 4 and 3 both low pulses xfer_err and is otherwise ignored. A write with both bits high is idle and causes no action.
- R6: Byte direction is checked against the state. In idle and while receiving, sr_h2d must be 1. While sending, sr_h2d must be 0. A byte in the wrong direction, or a byte request during the dispatch cycle, pulses xfer_err without byte_done and leaves the state unchanged.
- R7: In idle, the received byte is the command code and selects a table entry. The argument counter and response counter are cleared. A command with zero fixed arguments is dispatched on its code byte alone. Otherwise it is dispatched once the argument count reaches the table length.
- R8: If the argument length is variable, the first byte after the code is taken as the length, and a length of 0 dispatches at once. Only the first 32 arguments are stored. Later arguments are dropped but still count toward the length.
- R9: Dispatch raises dsp_req for exactly one cycle, with dsp_code and dsp_argc valid. arg_data returns the stored argument at arg_idx.
- R10: If the response length is variable, the first byte sent is the handler's reply size, and that many data bytes follow. If it is fixed, exactly the table count of bytes is sent. The engine returns to idle after the last byte, or directly after dispatch when the count is 0.
- R11: For a command the handler does not know (dsp_known low), a fixed response is sent as all-zero bytes and a variable response is a single size byte of 0.
- R12: Table codes, given as (arguments, response) with V meaning variable:
  - 0x10: (1, 0)
  - 0x20: (V, V)
  - 0x30: (4, 0)
  - 0x38: (0, 4)
  - 0x48: (1, 2)
  - 0x4C: (0, V)
  - 0x78: (0, V)
  - 0xE0: (0, 1)
  - every other code: (0, 0)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_we | input | 1 | Host write strobe for the handshake port |
| port_wdata | input | 8 | Value the host writes to the port |
| port_rdata | output | 8 | Port value, including the engine's acknowledge bit |
| sr_h2d | input | 1 | Shift direction: 1 means host to device |
| sr_in | input | 8 | Byte the host has shifted in |
| sr_out | output | 8 | Byte the engine presents to the host |
| byte_done | output | 1 | One-cycle strobe for each byte transferred |
| xfer_err | output | 1 | One-cycle strobe for each protocol error |
| dsp_req | output | 1 | One-cycle dispatch strobe |
| dsp_code | output | 8 | Command code being dispatched |
| dsp_argc | output | 8 | Number of argument bytes received |
| arg_idx | input | 5 | Index into the argument buffer |
| arg_data | output | 8 | Stored argument byte at arg_idx |
| dsp_known | input | 1 | Handler recognises dsp_code (sampled during dsp_req) |
| dsp_rsp_size | input | 8 | Handler reply size (sampled during dsp_req) |
| rsp_idx | output | 8 | Index of the reply byte requested from the handler |
| rsp_data | input | 8 | Handler reply byte at rsp_idx |

## Verification
A wrong state or counter inside the engine shows up at the ports within one transaction. Either dispatch fires on the wrong byte, so the number of byte_done strobes before dsp_req is off, or the engine returns to idle early or late. That leaves the next command byte misread and its dispatch code wrong. A stuck handshake decode shows up within two cycles as a port value that does not match the expected acknowledge bit, or as a missing or extra strobe. Zero-fill and size-byte errors appear directly in the bytes the host reads back.

// File: rtl/hs_pkg.sv
package hs_pkg;

   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_RECV = 2'd1,
      S_DISP = 2'd2,
      S_SEND = 2'd3
   } hs_state_t;

   typedef struct packed {
      logic       arg_var;
      logic [7:0] arg_len;
      logic       rsp_var;
      logic [7:0] rsp_len;
   } hs_len_t;

endpackage

// File: rtl/hs_len_table.sv
module hs_len_table #(
   parameter int CODE_W = 8,
   parameter int LEN_W  = 8
) (
   input  logic [CODE_W-1:0] code,
   output logic              arg_var,
   output logic [LEN_W-1:0]  arg_len,
   output logic              rsp_var,
   output logic [LEN_W-1:0]  rsp_len
);
   import hs_pkg::*;

   hs_len_t ent;

   if (CODE_W < 8) begin : g_bad_code_w
      $error("hs_len_table: CODE_W must be at least 8");
   end

   // R12: command length table, V marks variable
   always_comb begin
      ent = '{arg_var: 1'b0, arg_len: 8'd0, rsp_var: 1'b0, rsp_len: 8'd0};
      case (code[7:0])
         8'h10: ent.arg_len = 8'd1;
         8'h20: begin ent.arg_var = 1'b1; ent.rsp_var = 1'b1; end
         8'h30: ent.arg_len = 8'd4;
         8'h38: ent.rsp_len = 8'd4;
         8'h48: begin ent.arg_len = 8'd1; ent.rsp_len = 8'd2; end
         8'h4C: ent.rsp_var = 1'b1;
         8'h78: ent.rsp_var = 1'b1;
         8'hE0: ent.rsp_len = 8'd1;
         default: ;
      endcase
   end

   assign arg_var = ent.arg_var;
   assign rsp_var = ent.rsp_var;
   assign arg_len = LEN_W'(ent.arg_len);
   assign rsp_len = LEN_W'(ent.rsp_len);

endmodule

// File: rtl/hs_port_sync.sv
module hs_port_sync #(
   parameter int PORT_W  = 8,
   parameter int REQ_BIT = 4,
   parameter int ACK_BIT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [PORT_W-1:0] wdata,
   output logic [PORT_W-1:0] port_q,
   output logic              byte_evt,
   output logic              err_evt
);
   localparam logic [PORT_W-1:0] REQ_M   = PORT_W'(1) << REQ_BIT;
   localparam logic [PORT_W-1:0] ACK_M   = PORT_W'(1) << ACK_BIT;
   localparam logic [PORT_W-1:0] IDLE_V  = REQ_M | ACK_M;

   if (REQ_BIT >= PORT_W || ACK_BIT >= PORT_W || REQ_BIT == ACK_BIT) begin : g_bad_bits
      $error("hs_port_sync: handshake bit positions invalid");
   end

   logic [PORT_W-1:0] last_q;
   logic              changed;
   logic [1:0]        lines;

   assign changed = we && (wdata != last_q);
   assign lines   = {wdata[REQ_BIT], wdata[ACK_BIT]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         port_q   <= IDLE_V;
         last_q   <= IDLE_V;
         byte_evt <= 1'b0;
         err_evt  <= 1'b0;
      end else begin
         byte_evt <= 1'b0;
         err_evt  <= 1'b0;
         if (we && !changed) begin
            port_q <= wdata;
         end else if (changed) begin
            case (lines)
               2'b10: begin
                  port_q <= wdata | ACK_M;
                  last_q <= wdata | ACK_M;
               end
               2'b01: begin
                  port_q   <= wdata & ~ACK_M;
                  last_q   <= wdata & ~ACK_M;
                  byte_evt <= 1'b1;
               end
               2'b11: begin
                  port_q <= wdata;
                  last_q <= wdata;
               end
               default: begin
                  port_q  <= wdata;
                  last_q  <= wdata;
                  err_evt <= 1'b1;
               end
            endcase
         end
      end
   end

   p_same_value_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wdata == last_q) |=> (!byte_evt && !err_evt));

   p_release_sets_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (changed && wdata[REQ_BIT] && !wdata[ACK_BIT]) |=> (port_q[ACK_BIT] && !byte_evt));

   p_request_drops_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (changed && !wdata[REQ_BIT] && wdata[ACK_BIT]) |=> (!port_q[ACK_BIT] && byte_evt));

endmodule

// File: rtl/hs_arg_buf.sv
module hs_arg_buf #(
   parameter int DEPTH  = 32,
   parameter int DATA_W = 8,
   localparam int AIW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AIW-1:0]    wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [AIW-1:0]    rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   if (DEPTH < 1 || DEPTH > 255) begin : g_bad_depth
      $error("hs_arg_buf: DEPTH out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    mem[i] <= '0;
         else if (wr_en && wr_idx == AIW'(i))           mem[i] <= wr_data;
      end
   end

   assign rd_data = (int'(rd_idx) < DEPTH) ? mem[rd_idx] : '0;

   p_write_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && int'(wr_idx) < DEPTH) |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/hs_cmd_engine.sv
module hs_cmd_engine #(
   parameter int PORT_W    = 8,
   parameter int REQ_BIT   = 4,
   parameter int ACK_BIT   = 3,
   parameter int DATA_W    = 8,
   parameter int LEN_W     = 8,
   parameter int ARG_DEPTH = 32,
   localparam int AIW      = (ARG_DEPTH > 1) ? $clog2(ARG_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_we,
   input  logic [PORT_W-1:0] port_wdata,
   output logic [PORT_W-1:0] port_rdata,
   input  logic              sr_h2d,
   input  logic [DATA_W-1:0] sr_in,
   output logic [DATA_W-1:0] sr_out,
   output logic              byte_done,
   output logic              xfer_err,
   output logic              dsp_req,
   output logic [DATA_W-1:0] dsp_code,
   output logic [LEN_W-1:0]  dsp_argc,
   input  logic [AIW-1:0]    arg_idx,
   output logic [DATA_W-1:0] arg_data,
   input  logic              dsp_known,
   input  logic [LEN_W-1:0]  dsp_rsp_size,
   output logic [LEN_W-1:0]  rsp_idx,
   input  logic [DATA_W-1:0] rsp_data
);
   import hs_pkg::*;

   if (LEN_W < 8 || DATA_W < 8) begin : g_bad_w
      $error("hs_cmd_engine: LEN_W and DATA_W must be at least 8");
   end
   if (ARG_DEPTH >= (1 << LEN_W)) begin : g_bad_depth
      $error("hs_cmd_engine: ARG_DEPTH must fit in a length field");
   end

   localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(ARG_DEPTH);

   // handshake decode
   logic byte_evt, perr_evt;

   hs_port_sync #(.PORT_W(PORT_W), .REQ_BIT(REQ_BIT), .ACK_BIT(ACK_BIT)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (port_we),
      .wdata    (port_wdata),
      .port_q   (port_rdata),
      .byte_evt (byte_evt),
      .err_evt  (perr_evt)
   );

   // length lookup on the incoming byte
   logic             t_arg_var, t_rsp_var;
   logic [LEN_W-1:0] t_arg_len, t_rsp_len;

   hs_len_table #(.CODE_W(DATA_W), .LEN_W(LEN_W)) u_tbl (
      .code    (sr_in),
      .arg_var (t_arg_var),
      .arg_len (t_arg_len),
      .rsp_var (t_rsp_var),
      .rsp_len (t_rsp_len)
   );

   // state
   hs_state_t         state_q, state_d;
   logic [DATA_W-1:0] code_q, code_d;
   logic              arg_var_q, arg_var_d, rsp_var_q, rsp_var_d;
   logic [LEN_W-1:0]  arg_len_q, arg_len_d, rsp_len_q, rsp_len_d;
   logic [LEN_W-1:0]  argc_q, argc_d, rpos_q, rpos_d, rsz_q, rsz_d;
   logic              known_q, known_d;
   logic [DATA_W-1:0] sr_out_q, sr_out_d;
   logic              done_q, done_d, err_q, err_d;
   logic              wr_en;
   logic [LEN_W-1:0]  argc_inc, rpos_inc;
   logic [DATA_W-1:0] rsp_byte;

   assign argc_inc = argc_q + 1'b1;
   assign rpos_inc = rpos_q + 1'b1;
   assign rsp_byte = (known_q && rpos_q < rsz_q) ? rsp_data : '0;

   hs_arg_buf #(.DEPTH(ARG_DEPTH), .DATA_W(DATA_W)) u_args (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (argc_q[AIW-1:0]),
      .wr_data (sr_in),
      .rd_idx  (arg_idx),
      .rd_data (arg_data)
   );

   always_comb begin
      state_d   = state_q;
      code_d    = code_q;
      arg_var_d = arg_var_q;
      arg_len_d = arg_len_q;
      rsp_var_d = rsp_var_q;
      rsp_len_d = rsp_len_q;
      argc_d    = argc_q;
      rpos_d    = rpos_q;
      rsz_d     = rsz_q;
      known_d   = known_q;
      sr_out_d  = sr_out_q;
      done_d    = 1'b0;
      err_d     = perr_evt;
      wr_en     = 1'b0;
      case (state_q)
         S_IDLE: if (byte_evt) begin
            if (!sr_h2d) begin
               err_d = 1'b1;
            end else begin
               done_d    = 1'b1;
               code_d    = sr_in;
               arg_var_d = t_arg_var;
               arg_len_d = t_arg_len;
               rsp_var_d = t_rsp_var;
               rsp_len_d = t_rsp_len;
               argc_d    = '0;
               rpos_d    = '0;
               state_d   = (!t_arg_var && t_arg_len == '0) ? S_DISP : S_RECV;
            end
         end
         S_RECV: if (byte_evt) begin
            if (!sr_h2d) begin
               err_d = 1'b1;
            end else begin
               done_d = 1'b1;
               if (arg_var_q) begin
                  arg_var_d = 1'b0;
                  arg_len_d = LEN_W'(sr_in);
                  if (sr_in == '0) state_d = S_DISP;
               end else begin
                  wr_en  = (argc_q < DEPTH_L);
                  argc_d = argc_inc;
                  if (argc_inc == arg_len_q) state_d = S_DISP;
               end
            end
         end
         S_DISP: begin
            if (byte_evt) err_d = 1'b1;
            known_d = dsp_known;
            rsz_d   = dsp_known ? dsp_rsp_size : (rsp_var_q ? '0 : rsp_len_q);
            state_d = (!rsp_var_q && rsp_len_q == '0) ? S_IDLE : S_SEND;
         end
         S_SEND: if (byte_evt) begin
            if (sr_h2d) begin
               err_d = 1'b1;
            end else begin
               done_d = 1'b1;
               if (rsp_var_q) begin
                  rsp_var_d = 1'b0;
                  rsp_len_d = rsz_q;
                  sr_out_d  = DATA_W'(rsz_q);
                  if (rsz_q == '0) state_d = S_IDLE;
               end else begin
                  sr_out_d = rsp_byte;
                  rpos_d   = rpos_inc;
                  if (rpos_inc == rsp_len_q) state_d = S_IDLE;
               end
            end
         end
         default: state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= S_IDLE;
         code_q    <= '0;
         arg_var_q <= 1'b0;
         arg_len_q <= '0;
         rsp_var_q <= 1'b0;
         rsp_len_q <= '0;
         argc_q    <= '0;
         rpos_q    <= '0;
         rsz_q     <= '0;
         known_q   <= 1'b0;
         sr_out_q  <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q   <= state_d;
         code_q    <= code_d;
         arg_var_q <= arg_var_d;
         arg_len_q <= arg_len_d;
         rsp_var_q <= rsp_var_d;
         rsp_len_q <= rsp_len_d;
         argc_q    <= argc_d;
         rpos_q    <= rpos_d;
         rsz_q     <= rsz_d;
         known_q   <= known_d;
         sr_out_q  <= sr_out_d;
         done_q    <= done_d;
         err_q     <= err_d;
      end
   end

   assign sr_out    = sr_out_q;
   assign byte_done = done_q;
   assign xfer_err  = err_q;
   assign dsp_req   = (state_q == S_DISP);
   assign dsp_code  = code_q;
   assign dsp_argc  = arg_len_q;
   assign rsp_idx   = rpos_q;

   p_disp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_req |=> !dsp_req);

   p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(byte_done && xfer_err));

   p_dir_skip_send_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_evt && state_q == S_SEND && sr_h2d) |=> (xfer_err && !byte_done && state_q == S_SEND));

   p_dir_skip_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_evt && state_q == S_IDLE && !sr_h2d) |=> (xfer_err && state_q == S_IDLE));

   p_zero_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_evt && state_q == S_SEND && !sr_h2d && !rsp_var_q && !known_q) |=> (sr_out == '0));

   p_count_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_SEND && !rsp_var_q) |-> (rpos_q < rsp_len_q));

endmodule

// File: tb/hs_cmd_engine_bench.sv
module hs_cmd_engine_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_we = 1'b0;
   logic [7:0] port_wdata = 8'h18;
   logic [7:0] port_rdata;
   logic       sr_h2d = 1'b1;
   logic [7:0] sr_in = 8'h00;
   logic [7:0] sr_out;
   logic       byte_done, xfer_err, dsp_req;
   logic [7:0] dsp_code, dsp_argc;
   logic [4:0] arg_idx = 5'd0;
   logic [7:0] arg_data;
   logic       dsp_known;
   logic [7:0] dsp_rsp_size;
   logic [7:0] rsp_idx;
   logic [7:0] rsp_data;

   always #10 clk = ~clk;

   hs_cmd_engine u_hs_cmd_engine (
      .clk(clk), .rst_n(rst_n), .port_we(port_we), .port_wdata(port_wdata),
      .port_rdata(port_rdata), .sr_h2d(sr_h2d), .sr_in(sr_in), .sr_out(sr_out),
      .byte_done(byte_done), .xfer_err(xfer_err), .dsp_req(dsp_req),
      .dsp_code(dsp_code), .dsp_argc(dsp_argc), .arg_idx(arg_idx),
      .arg_data(arg_data), .dsp_known(dsp_known), .dsp_rsp_size(dsp_rsp_size),
      .rsp_idx(rsp_idx), .rsp_data(rsp_data)
   );

   // handler model
   function automatic logic h_known(input logic [7:0] c);
      return (c == 8'h10 || c == 8'h20 || c == 8'h30 || c == 8'h38 ||
              c == 8'h78 || c == 8'hE0);
   endfunction
   function automatic logic [7:0] h_size(input logic [7:0] c);
      case (c)
         8'h38: return 8'd4;
         8'hE0: return 8'd1;
         8'h78: return 8'd2;
         8'h20: return 8'd3;
         default: return 8'd0;
      endcase
   endfunction
   assign dsp_known    = h_known(dsp_code);
   assign dsp_rsp_size = h_size(dsp_code);
   assign rsp_data     = 8'hA0 + rsp_idx;

   int n_chk = 0, n_bad = 0;
   int done_cnt = 0, err_cnt = 0, disp_cnt = 0;
   logic [7:0] last_code, last_argc;

   always @(negedge clk) begin
      if (byte_done) done_cnt++;
      if (xfer_err)  err_cnt++;
      if (dsp_req) begin
         disp_cnt++;
         last_code = dsp_code;
         last_argc = dsp_argc;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_port(input logic [7:0] v);
      @(negedge clk);
      port_we = 1'b1; port_wdata = v;
      @(negedge clk);
      port_we = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      sr_h2d = 1'b1; sr_in = b;
      wr_port(8'h08);
      wr_port(8'h10);
   endtask

   task automatic recv_byte(output logic [7:0] b);
      sr_h2d = 1'b0;
      wr_port(8'h08);
      b = sr_out;
      wr_port(8'h10);
      sr_h2d = 1'b1;
   endtask

   // [31:24] code, [23:16] args sent, [15] var args, [14] var rsp, [13] known, [7:0] data bytes back
   localparam logic [31:0] VEC [9] = '{
      32'h38_00_2004, 32'hE0_00_2001, 32'h10_01_2000, 32'h30_04_2000,
      32'h48_01_0002, 32'h4C_00_4000, 32'h78_00_6002, 32'h20_03_E003,
      32'h55_00_0000
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] b;
      int d0, e0, p0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 port", port_rdata, 8'h18);
      check("R1 strobes", {byte_done, xfer_err, dsp_req}, 3'b000);
      check("R1 sr_out", sr_out, 8'h00);

      // vector walk: R7 R9 R10 R11 R12
      foreach (VEC[k]) begin
         logic [7:0] code, na, nr;
         logic av, rv, kn;
         code = VEC[k][31:24]; na = VEC[k][23:16];
         av = VEC[k][15]; rv = VEC[k][14]; kn = VEC[k][13]; nr = VEC[k][7:0];
         d0 = done_cnt; p0 = disp_cnt;
         send_byte(code);
         if (av) send_byte(na);
         for (int i = 0; i < int'(na); i++) send_byte(8'h11 + 8'(i));
         check("R9 one dispatch", disp_cnt, p0 + 1);
         check("R12 dispatch code", last_code, code);
         check("R7 argc", last_argc, na);
         if (na != 0) begin
            arg_idx = 5'd0; #1;
            check("R9 arg0", arg_data, 8'h11);
         end
         if (rv) begin
            recv_byte(b);
            check("R10 size byte", b, nr);
         end
         for (int i = 0; i < int'(nr); i++) begin
            recv_byte(b);
            check(kn ? "R10 data" : "R11 zero fill", b, kn ? 8'hA0 + 8'(i) : 8'h00);
         end
         check("R4 done count", done_cnt, d0 + 1 + int'(av) + int'(na) + int'(rv) + int'(nr));
         check("R3 port idle", port_rdata, 8'h18);
      end

      // R2: same value as last seen, from idle
      d0 = done_cnt; e0 = err_cnt;
      wr_port(8'h18);
      check("R2 idle rewrite strobes", done_cnt + err_cnt, d0 + e0);
      check("R2 idle rewrite port", port_rdata, 8'h18);
      // R4 ack drops; R2 rewriting ack-low value is quiet
      sr_h2d = 1'b1; sr_in = 8'h55;
      wr_port(8'h08);
      check("R4 ack low", port_rdata, 8'h00);
      check("R4 one done", done_cnt, d0 + 1);
      wr_port(8'h00);
      check("R2 repeat quiet", done_cnt + err_cnt, d0 + 1 + e0);
      check("R2 ack kept low", port_rdata, 8'h00);
      wr_port(8'h10);
      check("R3 release", port_rdata, 8'h18);

      // R5 both low
      d0 = done_cnt; e0 = err_cnt;
      wr_port(8'h00);
      check("R5 err strobe", err_cnt, e0 + 1);
      check("R5 no done", done_cnt, d0);
      wr_port(8'h18);
      check("R5 idle no err", err_cnt, e0 + 1);

      // R6 wrong direction in idle
      sr_h2d = 1'b0; sr_in = 8'hE0;
      wr_port(8'h08);
      wr_port(8'h10);
      check("R6 idle dir err", err_cnt, e0 + 2);
      check("R6 idle no done", done_cnt, d0);
      send_byte(8'hE0);
      recv_byte(b);
      check("R6 still idle", b, 8'hA0);

      // R6 wrong direction while sending
      send_byte(8'h38);
      d0 = done_cnt; e0 = err_cnt;
      sr_h2d = 1'b1;
      wr_port(8'h08);
      wr_port(8'h10);
      check("R6 send dir err", err_cnt, e0 + 1);
      check("R6 send no done", done_cnt, d0);
      for (int i = 0; i < 4; i++) begin
         recv_byte(b);
         check("R6 send resumes", b, 8'hA0 + 8'(i));
      end

      // R8 overflow: 40 arguments, 32 stored
      p0 = disp_cnt;
      send_byte(8'h20);
      send_byte(8'd40);
      for (int i = 0; i < 40; i++) begin
         if (i == 39) check("R8 no early dispatch", disp_cnt, p0);
         send_byte(8'(i));
      end
      check("R8 dispatch after 40", disp_cnt, p0 + 1);
      check("R8 argc", last_argc, 8'd40);
      arg_idx = 5'd31; #1;
      check("R8 last stored", arg_data, 8'd31);
      recv_byte(b);
      check("R10 var size", b, 8'd3);
      for (int i = 0; i < 3; i++) recv_byte(b);
      check("R10 last byte", b, 8'hA2);

      // R8 variable length of zero dispatches at once
      p0 = disp_cnt;
      send_byte(8'h20);
      send_byte(8'd0);
      check("R8 zero length dispatch", disp_cnt, p0 + 1);
      recv_byte(b);
      check("R8 zero length size", b, 8'd3);
      for (int i = 0; i < 3; i++) recv_byte(b);
      send_byte(8'h55);
      check("R7 back to idle", last_code, 8'h55);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule